// File: doc/BRIEF.md
# Write-Enable Latch and Status Protection Unit

This unit sits behind the command decoder of a serial memory slave. It holds the write-enable latch and the status byte, and it decides whether each write the host asks for may proceed. The decoder sends it single-cycle strobes: latch set, latch clear, status-write (with a data byte), memory-write (once per data byte) and end of transaction (the chip-select rising edge). The unit returns a grant for each write in the same cycle as the request, together with the status byte that the status-read command shifts out.

The latch starts clear after reset. Any transaction that asks for a write, whether the write is granted or refused, clears the latch when that transaction ends. Each new write transaction therefore needs a fresh set-latch command first. Inside one transaction the latch stays set, so a burst of memory bytes is granted byte after byte. The active-low protect pin blocks only status writes. Memory writes depend on the latch alone. A non-volatile status value is modelled as the reset value of the storage bits.

Top module: `wel_guard`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the status byte reads 0x00, the latch is clear, and neither grant is asserted for any request.
- R2: A set-latch strobe sets the latch at the next clock edge. The latch is seen as status bit 1 reading 1.
- R3: A clear-latch strobe clears the latch (status bit 1 reads 0) at the next clock edge.
- R4: mem_grant_o is high in the same cycle as mem_wr_i exactly when the latch is set.
- R5: stat_grant_o is high in the same cycle as stat_wr_i exactly when the latch is set and wp_n_i is high. A granted write loads bits 7..4 and bit 0 from the data byte at the next edge.
- R6: Status bits 3..2 always read 0, and no status write changes bit 1.
- R7: A refused status write leaves the status byte unchanged.
- R8: An end-of-transaction strobe clears the latch if that transaction carried any write request, granted or refused. Between the requests and that strobe the latch stays set, so multi-byte memory writes are granted on every byte.
- R9: An end-of-transaction strobe with no write request in its transaction leaves the latch unchanged.
- R10: When set and clear strobes arrive in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_en_i | input | 1 | Set-latch command strobe |
| clr_en_i | input | 1 | Clear-latch command strobe |
| stat_wr_i | input | 1 | Status-write data byte strobe |
| stat_data_i | input | 8 | Status byte to write |
| mem_wr_i | input | 1 | Memory-write data byte strobe |
| xfer_end_i | input | 1 | Transaction end (chip-select rising edge) |
| wp_n_i | input | 1 | Write-protect pin, active low, guards status only |
| status_o | output | 8 | Status byte for status reads |
| stat_grant_o | output | 1 | Status write allowed this cycle |
| mem_grant_o | output | 1 | Memory byte write allowed this cycle |

## Verification
The stimulus runs the latch through full command sequences. These include memory writes with the latch clear, with the latch set and as a two-byte burst, followed by transaction ends with and without writes. This separates a latch that clears per transaction from one that clears per byte or at every transaction end. Status writes are tried with all ones, with only the read-only positions set, and with protect asserted, which shows whether the masks and the pin gate the correct bits. A final case resets the unit while the latch and storage hold non-zero values.

// File: rtl/wel_pkg.sv
// Package: shared layout constants for the write-enable/status unit.
// Assumes an 8-bit status byte with the latch flag at a fixed bit.
package wel_pkg;
    localparam int          STAT_W   = 8;
    localparam int          WEL_BIT  = 1;
    localparam logic [7:0]  WR_MASK  = 8'hF1;   // bits 7..4 and 0 writable
    localparam logic [7:0]  STAT_RST = 8'h00;   // modelled non-volatile value
endpackage

// File: rtl/wel_latch.sv
// Module: write-enable latch with per-transaction auto-clear.
// Assumes strobes are single-cycle and xfer_end marks chip-select rising.
module wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic wr_req_i,
    input  logic xfer_end_i,
    output logic wel_o
);
    logic wel_q;
    logic pend_q;
    logic end_clr;

    // A transaction ending after any write request drops the latch.
    assign end_clr = xfer_end_i && (pend_q || wr_req_i);

    // Track whether the open transaction requested a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (xfer_end_i) pend_q <= 1'b0;
        else if (wr_req_i)   pend_q <= 1'b1;
    end

    // Latch update: clears take priority over the set command.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wel_q <= 1'b0;
        else if (end_clr || clr_en_i) wel_q <= 1'b0;
        else if (set_en_i)           wel_q <= 1'b1;
    end

    assign wel_o = wel_q;

    p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end_i && pend_q) |=> !wel_q);
    p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> !wel_q);
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en_i && !clr_en_i && !xfer_end_i) |=> wel_q);
endmodule

// File: rtl/wel_status_reg.sv
// Module: status byte storage; merges the latch flag, forces fixed zeros.
// Assumes wr_en_i is already qualified by the grant logic.
module wel_status_reg #(
    parameter int               STAT_W   = wel_pkg::STAT_W,
    parameter int               WEL_BIT  = wel_pkg::WEL_BIT,
    parameter logic [STAT_W-1:0] WR_MASK  = wel_pkg::WR_MASK,
    parameter logic [STAT_W-1:0] STAT_RST = wel_pkg::STAT_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              wel_i,
    output logic [STAT_W-1:0] status_o
);
    localparam logic [STAT_W-1:0] WEL_MASK = STAT_W'(1) << WEL_BIT;

    logic [STAT_W-1:0] stor_q;

    // Load only the writable positions on a granted write.
    always_ff @(posedge clk) begin
        if (!rst_n)       stor_q <= STAT_RST & WR_MASK;
        else if (wr_en_i) stor_q <= wdata_i & WR_MASK;
    end

    // Present storage with the live latch flag inserted.
    always_comb begin
        status_o = stor_q;
        status_o[WEL_BIT] = wel_i;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(stor_q));
    p_fixed_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~(WR_MASK | WEL_MASK)) == '0);
endmodule

// File: rtl/wel_grant.sv
// Module: write grant decode from latch state and protect pin.
// Assumes protect guards the status register only.
module wel_grant (
    input  logic wel_i,
    input  logic wp_n_i,
    input  logic stat_wr_i,
    input  logic mem_wr_i,
    output logic stat_grant_o,
    output logic mem_grant_o
);
    // Grants are combinational so the data byte commits in its own cycle.
    always_comb begin
        mem_grant_o  = mem_wr_i && wel_i;
        stat_grant_o = stat_wr_i && wel_i && wp_n_i;
    end
endmodule

// File: rtl/wel_guard.sv
// Module: top of the write-enable latch and status protection unit.
// Assumes decoder strobes are synchronous to clk and one cycle wide.
module wel_guard #(
    parameter int STAT_W = wel_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_data_i,
    input  logic              mem_wr_i,
    input  logic              xfer_end_i,
    input  logic              wp_n_i,
    output logic [STAT_W-1:0] status_o,
    output logic              stat_grant_o,
    output logic              mem_grant_o
);
    logic wel;
    logic wr_req;

    // Any write request, granted or not, arms the end-of-transaction clear.
    assign wr_req = stat_wr_i || mem_wr_i;

    wel_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (set_en_i),
        .clr_en_i   (clr_en_i),
        .wr_req_i   (wr_req),
        .xfer_end_i (xfer_end_i),
        .wel_o      (wel)
    );

    wel_grant u_grant (
        .wel_i        (wel),
        .wp_n_i       (wp_n_i),
        .stat_wr_i    (stat_wr_i),
        .mem_wr_i     (mem_wr_i),
        .stat_grant_o (stat_grant_o),
        .mem_grant_o  (mem_grant_o)
    );

    wel_status_reg #(.STAT_W(STAT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (stat_grant_o),
        .wdata_i  (stat_data_i),
        .wel_i    (wel),
        .status_o (status_o)
    );

    p_mem_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_grant_o |-> status_o[wel_pkg::WEL_BIT]);
    p_stat_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_grant_o |-> (status_o[wel_pkg::WEL_BIT] && wp_n_i));
    p_no_idle_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr_i && !mem_wr_i) |-> (!stat_grant_o && !mem_grant_o));
endmodule

// File: tb/wel_guard_bench.sv
// Bench: table-driven check of the latch/status unit, then reset directed test.
module wel_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       set_en, clr_en, stat_wr, mem_wr, xfer_end, wp_n;
    logic [7:0] stat_data;
    logic [7:0] status;
    logic       stat_grant, mem_grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wel_guard u_wel_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en_i     (set_en),
        .clr_en_i     (clr_en),
        .stat_wr_i    (stat_wr),
        .stat_data_i  (stat_data),
        .mem_wr_i     (mem_wr),
        .xfer_end_i   (xfer_end),
        .wp_n_i       (wp_n),
        .status_o     (status),
        .stat_grant_o (stat_grant),
        .mem_grant_o  (mem_grant)
    );

    typedef struct packed {
        logic       set, clr, swr;
        logic [7:0] sd;
        logic       mwr, xe, wpn;
        logic       esg, emg;
        logic [7:0] est;   // status expected after the edge
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h00}, // idle
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1, 1'b0,1'b0,8'h00}, // R4 mem refused
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'h00}, // R8 end
        '{1'b0,1'b0,1'b1,8'hFF,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h00}, // R5 R7 refused
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'h00}, // end
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h02}, // R2 set
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'h02}, // R9 end no write
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1, 1'b0,1'b1,8'h02}, // R4 byte 1
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1, 1'b0,1'b1,8'h02}, // R8 byte 2
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'h00}, // R8 clears
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h02}, // set
        '{1'b0,1'b0,1'b1,8'hFF,1'b0,1'b0,1'b1, 1'b1,1'b0,8'hF3}, // R5 R6 granted
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'hF1}, // R8
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hF3}, // set
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,8'hF3}, // R5 R7 protected
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'hF1}, // R8 refused clears
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hF3}, // set
        '{1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hF1}, // R3 clear
        '{1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hF1}, // R10 both
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hF3}, // set
        '{1'b0,1'b0,1'b1,8'h0E,1'b0,1'b0,1'b1, 1'b1,1'b0,8'h02}, // R6 fixed bits
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b0,1'b0,8'h00}  // end
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        set_en = v.set; clr_en = v.clr; stat_wr = v.swr; stat_data = v.sd;
        mem_wr = v.mwr; xfer_end = v.xe; wp_n = v.wpn;
    endtask

    localparam vec_t IDLE = '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00};

    initial begin
        drive(IDLE);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 status", status, 8'h00);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            #1;
            check("R5 stat_grant", {7'b0, stat_grant}, {7'b0, VECS[i].esg});
            check("R4 mem_grant",  {7'b0, mem_grant},  {7'b0, VECS[i].emg});
            @(negedge clk);
            drive(IDLE);
            check("R2/R3/R6/R8 status", status, VECS[i].est);
        end
        // R1: reset with latch and storage non-zero
        set_en = 1'b1; @(negedge clk); drive(IDLE);
        stat_wr = 1'b1; stat_data = 8'hA1; @(negedge clk); drive(IDLE);
        check("R5 pre-reset status", status, 8'hA3);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        #1 check("R1 status after reset", status, 8'h00);
        mem_wr = 1'b1; stat_wr = 1'b1; stat_data = 8'hFF;
        #1 check("R1 no grants", {6'b0, stat_grant, mem_grant}, 8'h00);
        @(negedge clk); drive(IDLE);
        check("R1 status after refused", status, 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule